// File: doc/BRIEF.md
# Pin Role Discovery Scanner

This block works out which pins of an unknown logic chip are inputs and which are outputs. The chip's usable pins sit in a packed vector with no gaps: bit 0 is socket pin 1, and the power and ground pins are left out. The block never drives a pin hard. For each pin it only chooses whether a weak pull lifts that pin or lets it sink, and it reads back every pin level.

A single `start` pulse launches a fixed run of 2×PINS+2 pull patterns in this order:
- every pin low;
- one high moved across each position from bit 0 upward;
- every pin high;
- one low moved across each position from bit 0 upward.

Each pattern is held for `SETTLE_CYC` clock cycles. The whole pin word is then sampled. A pin that reads back against its own pull is classed as an output. A pin whose pull change moves any other pin, compared with the uniform pattern of the same polarity, is classed as an input.

At the end the block reports both masks and two flags. One flag proves a 16-pin part. The other advises that a 14-pin trial should come first. The scan data serves only this classification and is not kept as reference data for later vector tests.

Top module: `pin_role_scanner`

## Requirements
- R1: After reset `pull_hi` is all zeros, and `busy`, `done`, `out_mask`, `in_mask`, `is_16pin` and `try_14_first` are all 0.
- R2: A scan applies exactly 2×PINS+2 pull words in order, with pattern k defined as follows:
  - k=0 is all zeros;
  - k=1..PINS has only bit k-1 set;
  - k=PINS+1 is all ones;
  - k=PINS+2..2×PINS+1 has only bit k-PINS-2 cleared.
- R3: Every pattern stays on `pull_hi` for exactly SETTLE_CYC cycles. `pin_in` is sampled on the last of those cycles, so a pin response delayed by up to SETTLE_CYC-1 registers is still seen.
- R4: A bit of `out_mask` is 1 when, in any pattern, the sampled pin level differs from the pull level applied to that pin.
- R5: A bit j of `in_mask` is 1 when, in either single-pin pattern for bit j, some other pin samples differently from the uniform pattern of the same polarity (all-low for the walking high, all-high for the walking low).
- R6: `is_16pin` is 1 when bit PINS-1 or bit PINS-2 is set in `out_mask` OR `in_mask`.
- R7: `try_14_first` is 1 when `is_16pin` is 0 and bits PINS-3..0 of (`out_mask` OR `in_mask`) are all 1.
- R8: `done` is high for exactly one cycle per scan. The masks and flags change only on the edge that raises `done` and stay constant until the next `done`. A `start` that arrives while `busy` is high is ignored.
- R9: `done` rises on the clock edge SETTLE_CYC×(2×PINS+2)+1 edges after the edge that accepts `start`. `busy` is high from the accepting edge up to, but not including, the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a scan when the block is idle |
| pin_in | input | PINS | Sampled levels of the packed chip pins |
| pull_hi | output | PINS | Per-pin weak-pull selection, 1 = pull high |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| out_mask | output | PINS | Pins classed as outputs |
| in_mask | output | PINS | Pins classed as inputs |
| is_16pin | output | 1 | One of the two top positions showed a role |
| try_14_first | output | 1 | 14-pin trial is advised first |

## Verification
Two coincidences are of interest. The first is a stray `start` landing on the same clock edge as a pattern sample. The bench raises `start` so that it is sampled exactly on a sampling edge in the middle of a scan. That scan must still finish with the normal latency, the normal pattern order and the correct masks. The second is the next scan beginning right after a `done`. Here the previous verdict must stay on the outputs, unchanged, through the whole new scan until its own `done`. The chip model's response passes through SETTLE_CYC-1 registers, so any early sample yields wrong masks.

// File: rtl/prd_pkg.sv
package prd_pkg;

    parameter int unsigned PINS     = 14;
    localparam int unsigned NPAT    = 2 * PINS + 2;
    localparam int unsigned PAT_W   = $clog2(NPAT);
    localparam int unsigned BIG_TAIL = 2;

    typedef logic [PINS-1:0]  pinvec_t;
    typedef logic [PAT_W-1:0] patidx_t;

    typedef enum logic [1:0] {
        PH_BASE_LO,
        PH_WALK_HI,
        PH_BASE_HI,
        PH_WALK_LO
    } phase_e;

    typedef struct packed {
        phase_e  phase;
        patidx_t pos;
    } patinfo_t;

    typedef struct packed {
        pinvec_t outs;
        pinvec_t ins;
        logic    big;
        logic    small_first;
    } verdict_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_FIN
    } seq_state_e;

    function automatic patinfo_t decode_idx(patidx_t idx);
        patinfo_t    r;
        int unsigned i;
        i     = 32'(idx);
        r.pos = '0;
        if (i == 0) begin
            r.phase = PH_BASE_LO;
        end else if (i <= PINS) begin
            r.phase = PH_WALK_HI;
            r.pos   = PAT_W'(i - 1);
        end else if (i == PINS + 1) begin
            r.phase = PH_BASE_HI;
        end else begin
            r.phase = PH_WALK_LO;
            r.pos   = PAT_W'(i - PINS - 2);
        end
        return r;
    endfunction

    function automatic pinvec_t drive_for(patinfo_t pi);
        pinvec_t one;
        one = pinvec_t'(1) << pi.pos;
        case (pi.phase)
            PH_BASE_LO: return '0;
            PH_WALK_HI: return one;
            PH_BASE_HI: return '1;
            default:    return ~one;
        endcase
    endfunction

    function automatic verdict_t classify(pinvec_t outs, pinvec_t ins);
        verdict_t v;
        pinvec_t  seen;
        seen          = outs | ins;
        v.outs        = outs;
        v.ins         = ins;
        v.big         = |seen[PINS-1 -: BIG_TAIL];
        v.small_first = !v.big && (&seen[PINS-BIG_TAIL-1:0]);
        return v;
    endfunction

endpackage

// File: rtl/prd_pattern_seq.sv
module prd_pattern_seq
    import prd_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output pinvec_t  pull_hi,
    output patinfo_t info,
    output logic     sample_en,
    output logic     busy,
    output logic     fin
);

    localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    seq_state_e       state;
    patidx_t          idx;
    logic [CNT_W-1:0] cnt;
    pinvec_t          pull_q;

    assign info      = decode_idx(idx);
    assign sample_en = (state == SQ_RUN) && (cnt == CNT_LAST);
    assign busy      = (state != SQ_IDLE);
    assign fin       = (state == SQ_FIN);
    assign pull_hi   = pull_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            idx    <= '0;
            cnt    <= '0;
            pull_q <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state  <= SQ_RUN;
                        idx    <= '0;
                        cnt    <= '0;
                        pull_q <= drive_for(decode_idx('0));
                    end
                end
                SQ_RUN: begin
                    if (sample_en) begin
                        cnt <= '0;
                        if (idx == patidx_t'(NPAT - 1)) begin
                            state  <= SQ_FIN;
                            pull_q <= '0;
                        end else begin
                            idx    <= idx + patidx_t'(1);
                            pull_q <= drive_for(decode_idx(idx + patidx_t'(1)));
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R2
    walk_hi_single_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_RUN && info.phase == PH_WALK_HI) |-> $countones(pull_q) == 1);

    // R2
    walk_lo_single_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_RUN && info.phase == PH_WALK_LO) |-> $countones(~pull_q) == 1);

    // R3
    pull_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_RUN && !sample_en) |=> $stable(pull_q));

    // R3
    settle_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_LAST);

endmodule

// File: rtl/prd_role_accum.sv
module prd_role_accum
    import prd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     sample_en,
    input  patinfo_t info,
    input  pinvec_t  pull_hi,
    input  pinvec_t  pin_in,
    output pinvec_t  outs,
    output pinvec_t  ins
);

    pinvec_t base_lo;
    pinvec_t base_hi;
    pinvec_t ref_word;
    pinvec_t moved;
    logic    walking;

    always_comb begin
        walking  = (info.phase == PH_WALK_HI) || (info.phase == PH_WALK_LO);
        ref_word = (info.phase == PH_WALK_HI) ? base_lo : base_hi;
        moved    = (pin_in ^ ref_word) & ~(pinvec_t'(1) << info.pos);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            base_lo <= '0;
            base_hi <= '0;
        end else if (sample_en) begin
            if (info.phase == PH_BASE_LO) base_lo <= pin_in;
            if (info.phase == PH_BASE_HI) base_hi <= pin_in;
        end
    end

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic out_f;
        logic in_f;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                out_f <= 1'b0;
                in_f  <= 1'b0;
            end else if (sample_en) begin
                if (pin_in[g] != pull_hi[g]) out_f <= 1'b1;
                if (walking && (32'(info.pos) == g) && (|moved)) in_f <= 1'b1;
            end
        end
        assign outs[g] = out_f;
        assign ins[g]  = in_f;
    end

    // R4
    outs_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((outs & $past(outs)) == $past(outs)));

    // R5
    ins_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && !(sample_en && walking)) |=> $stable(ins));

endmodule

// File: rtl/pin_role_scanner.sv
module pin_role_scanner
    import prd_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pull_hi,
    output logic            busy,
    output logic            done,
    output logic [PINS-1:0] out_mask,
    output logic [PINS-1:0] in_mask,
    output logic            is_16pin,
    output logic            try_14_first
);

    patinfo_t info;
    logic     sample_en;
    logic     fin;
    logic     accept;
    pinvec_t  acc_outs;
    pinvec_t  acc_ins;
    verdict_t verdict_q;
    logic     done_q;

    assign accept = start && !busy;

    prd_pattern_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .pull_hi   (pull_hi),
        .info      (info),
        .sample_en (sample_en),
        .busy      (busy),
        .fin       (fin)
    );

    prd_role_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .sample_en (sample_en),
        .info      (info),
        .pull_hi   (pull_hi),
        .pin_in    (pin_in),
        .outs      (acc_outs),
        .ins       (acc_ins)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= fin;
            if (fin) verdict_q <= classify(acc_outs, acc_ins);
        end
    end

    assign done         = done_q;
    assign out_mask     = verdict_q.outs;
    assign in_mask      = verdict_q.ins;
    assign is_16pin     = verdict_q.big;
    assign try_14_first = verdict_q.small_first;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(out_mask) && $stable(in_mask) && $stable(is_16pin)));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        is_16pin |-> !try_14_first);

endmodule

// File: tb/pin_role_scanner_bench.sv
`timescale 1ns/1ps
module pin_role_scanner_bench;
    import prd_pkg::*;

    localparam int SETTLE = 4;
    localparam int N      = PINS;
    localparam int LAT    = SETTLE * (2 * N + 2) + 1;

    logic    clk = 1'b0;
    logic    rst = 1'b1;
    logic    start = 1'b0;
    pinvec_t pin_in, pull_hi, out_mask, in_mask;
    logic    busy, done, is_16pin, try_14_first;
    pinvec_t d1, d2;

    int role[N];
    int sa[N];
    int sb[N];
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pin_role_scanner #(.SETTLE_CYC(SETTLE)) u_pin_role_scanner (
        .clk(clk), .rst(rst), .start(start), .pin_in(pin_in), .pull_hi(pull_hi),
        .busy(busy), .done(done), .out_mask(out_mask), .in_mask(in_mask),
        .is_16pin(is_16pin), .try_14_first(try_14_first)
    );

    // chip model: role 0 passive, 1 input, 2 output (NAND of sa/sb, constant high if sa < 0)
    function automatic pinvec_t chip(pinvec_t p);
        pinvec_t v;
        for (int i = 0; i < N; i++) begin
            if (role[i] == 2) v[i] = (sa[i] < 0) ? 1'b1 : ~(p[sa[i]] & p[sb[i]]);
            else              v[i] = p[i];
        end
        return v;
    endfunction

    always @(posedge clk) begin
        d1     <= chip(pull_hi);
        d2     <= d1;
        pin_in <= d2;
    end

    function automatic pinvec_t exp_pat(int k);
        if (k == 0)     return '0;
        if (k <= N)     return pinvec_t'(1) << (k - 1);
        if (k == N + 1) return '1;
        return ~(pinvec_t'(1) << (k - N - 2));
    endfunction

    function automatic pinvec_t exp_outs();
        pinvec_t m = '0;
        for (int i = 0; i < N; i++) if (role[i] == 2) m[i] = 1'b1;
        return m;
    endfunction

    function automatic pinvec_t exp_ins();
        pinvec_t m = '0;
        for (int i = 0; i < N; i++)
            if (role[i] == 2 && sa[i] >= 0) begin m[sa[i]] = 1'b1; m[sb[i]] = 1'b1; end
        return m;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_chip();
        for (int i = 0; i < N; i++) begin role[i] = 0; sa[i] = -1; sb[i] = -1; end
    endtask

    task automatic gate(int o, int a, int b);
        role[o] = 2; sa[o] = a; sb[o] = b; role[a] = 1; role[b] = 1;
    endtask

    task automatic run_scan(bit poke);
        int      edges;
        int      bad_pat;
        int      bad_hold;
        pinvec_t om, im, eo, ei, seen;
        logic    e16, e14;
        om = out_mask; im = in_mask;
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        edges = 0; bad_pat = 0; bad_hold = 0;
        while (edges < 400) begin
            if (edges < LAT - 1 && pull_hi != exp_pat(edges / SETTLE)) bad_pat++;
            if (done) break;
            if (out_mask != om || in_mask != im) bad_hold++;
            start = poke && (edges == 35);
            @(posedge clk); edges++;
            @(negedge clk);
        end
        start = 1'b0;
        eo = exp_outs(); ei = exp_ins(); seen = eo | ei;
        e16 = seen[N-1] | seen[N-2];
        e14 = !e16 && (&seen[N-3:0]);
        check(edges == LAT, "R9 done latency", edges, LAT);
        check(bad_pat == 0, "R2/R3 pattern order and hold", bad_pat, 0);
        check(bad_hold == 0, "R8 verdict held during scan", bad_hold, 0);
        check(out_mask == eo, "R4 out_mask", out_mask, eo);
        check(in_mask == ei, "R5 in_mask", in_mask, ei);
        check(is_16pin == e16, "R6 is_16pin", is_16pin, e16);
        check(try_14_first == e14, "R7 try_14_first", try_14_first, e14);
        check(!busy, "R9 busy low at done", busy, 0);
        @(negedge clk);
        check(!done, "R8 done single cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        clear_chip();
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1
        check(pull_hi == '0 && !busy && !done, "R1 reset controls", {pull_hi, busy, done}, 0);
        check(out_mask == '0 && in_mask == '0 && !is_16pin && !try_14_first,
              "R1 reset results", {out_mask, in_mask}, 0);

        // empty socket
        run_scan(1'b0);
        // quad NAND on the 14-pin layout: full coverage, top two idle
        clear_chip();
        gate(2, 0, 1); gate(5, 3, 4); gate(6, 7, 8); gate(9, 10, 11);
        run_scan(1'b0);
        // same chip, stray start on a sample edge mid-scan (R8 ignore)
        run_scan(1'b1);
        // one input missing from coverage: inverter on 9
        clear_chip();
        gate(2, 0, 1); gate(5, 3, 4); gate(6, 7, 8); gate(9, 10, 10);
        run_scan(1'b0);
        // output on the top position proves 16-pin
        clear_chip();
        gate(13, 0, 0);
        run_scan(1'b0);
        // input on the second highest position
        clear_chip();
        gate(3, 12, 5);
        run_scan(1'b0);
        // constant-high output, no inputs
        clear_chip();
        role[7] = 2;
        run_scan(1'b0);

        for (int r = 0; r < 10; r++) begin
            int ilist[N];
            int ni;
            clear_chip();
            ni = 0;
            for (int i = 0; i < N; i++) begin
                role[i] = int'($urandom % 3);
                if (role[i] == 1) begin ilist[ni] = i; ni++; end
            end
            for (int i = 0; i < N; i++) begin
                if (role[i] == 2 && ni > 0) begin
                    sa[i] = ilist[$urandom % ni];
                    sb[i] = ilist[$urandom % ni];
                end
            end
            run_scan(r == 3);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule